// File: doc/BRIEF.md
# Restoring Fractional Divider

This block divides one unsigned 16-bit fixed-point value by another. Both operands use a 1.14 format in which 0x4000 stands for 1.0. It returns a 15-bit quotient in the same format. A host loads the operands one byte at a time through four write strobes that share one byte-wide data bus. It then polls a busy flag and reads the quotient.

The dividend sits in a latch that no division ever modifies, so one dividend can serve several divisors. Writing the upper divisor byte arms the unit. This clears the quotient and copies the dividend latch into the working remainder. Writing the lower divisor byte starts the run. The divisor is kept inverted, so each step is a single addition whose carry-out is the next quotient bit. When the trial subtraction succeeds, the difference is written back already shifted left by one bit, so no separate shift step is needed. The unit performs one such step per clock and needs fifteen steps in all. Results are defined only when the dividend is less than twice the divisor.

Top module: `frac_div`

## Requirements
- R1: After synchronous active-low reset, `busy` is 0 and `rd_quot` reads 0x0000.
- R2: The dividend latch takes `wr_data` into bits 15:8 on `wr_dvd_hi` and into bits 7:0 on `wr_dvd_lo`. A division never changes the latch, so a later division that writes only the divisor uses the same dividend.
- R3: A `wr_dvd_hi`-style write to the divisor upper byte (`wr_dvs_hi`) loads divisor bits 15:8, clears the quotient so that `rd_quot` reads 0 on the next cycle, reloads the remainder from the dividend latch, and drops `busy`.
- R4: A `wr_dvs_lo` write loads divisor bits 7:0 and starts a division. `busy` is 1 in the cycle after the write.
- R5: `busy` stays high for exactly 15 clock cycles after a start and then falls by itself.
- R6: Once `busy` falls, `rd_quot` equals {Q, 1'b0}, where Q = floor(dividend × 2^14 / divisor) over 15 bits. This holds for any divisor and any dividend below twice the divisor.
- R7: The following results hold (dividend / divisor = Q): 0x4000/0x4000 = 0x4000, 0x5555/0x4000 = 0x5555, 0x2AAA/0x4000 = 0x2AAA, 0x2AAA/0x2AAA = 0x4000, 0x5555/0x5555 = 0x4000.
- R8: A `wr_dvs_lo` write while `busy` restarts the division from the current dividend latch and divisor latch contents. A fresh 15-cycle run follows.
- R9: The quotient holds until the next divisor write. Writes to the dividend latch do not disturb `rd_quot`, either during a run or after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_dvd_hi | input | 1 | Write `wr_data` to dividend bits 15:8 |
| wr_dvd_lo | input | 1 | Write `wr_data` to dividend bits 7:0 |
| wr_dvs_hi | input | 1 | Write divisor bits 15:8, clear quotient, reload remainder |
| wr_dvs_lo | input | 1 | Write divisor bits 7:0 and start |
| wr_data | input | 8 | Byte written by the strobes |
| rd_quot | output | 16 | Quotient, left-aligned (bit 0 is 0) |
| busy | output | 1 | High while the divide steps run |

## Verification
The bench builds the unit with its default 16-bit operand width. That is the width the byte-lane host interface is designed for. With this width, a grid of 64 divisors spans the whole 16-bit range, from 0x0001 to 0xFFFF. For each divisor, 40 dividends run from zero up to the largest legal value, twice the divisor minus one. This sweep covers the quotient extremes, including all-ones, and every carry pattern of the 17-bit remainder. Separate sequences cover divisor-only reuse of the dividend, mid-run restarts, and arm aborts.

// File: rtl/frac_div_pkg.sv
// Package: shared types and default sizes for the fractional divider.
// Assumes the operand width is even, so it splits into two host byte lanes.
package frac_div_pkg;
    parameter int unsigned DIV_W_DEF = 16;

    // One strobe per writable byte of the operand latches.
    typedef struct packed {
        logic dvd_hi;
        logic dvd_lo;
        logic dvs_hi;
        logic dvs_lo;
    } wr_strb_t;
endpackage

// File: rtl/fd_operand_latch.sv
// Module: operand latches. Holds the dividend as written and the divisor in
// inverted form, each loaded one half-width lane at a time.
// Assumes W is even; lane 1 is the upper half.
module fd_operand_latch
    import frac_div_pkg::*;
#(
    parameter int unsigned W = DIV_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  wr_strb_t             strb,
    input  logic [W/2-1:0]       wr_data,
    output logic [W-1:0]         dvd_q,
    output logic [W-1:0]         dvs_inv_q
);
    localparam int unsigned H = W / 2;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic dvd_we;
        logic dvs_we;
        assign dvd_we = (g == 1) ? strb.dvd_hi : strb.dvd_lo;
        assign dvs_we = (g == 1) ? strb.dvs_hi : strb.dvs_lo;

        // Dividend lane: written only by the host.
        always_ff @(posedge clk) begin
            if (!rst_n)      dvd_q[g*H +: H] <= '0;
            else if (dvd_we) dvd_q[g*H +: H] <= wr_data;
        end

        // Divisor lane: stored inverted so the datapath subtracts by adding.
        always_ff @(posedge clk) begin
            if (!rst_n)      dvs_inv_q[g*H +: H] <= '1;
            else if (dvs_we) dvs_inv_q[g*H +: H] <= ~wr_data;
        end
    end

    assert_dvd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb.dvd_hi && !strb.dvd_lo) |=> $stable(dvd_q));

    assert_dvs_lo_inv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        strb.dvs_lo |=> (dvs_inv_q[H-1:0] == ~$past(wr_data)));
endmodule

// File: rtl/fd_step_ctrl.sv
// Module: step sequencer. Runs the fixed number of divide steps after a
// start. An arm request cancels a run; a start always wins over an arm.
module fd_step_ctrl #(
    parameter int unsigned STEPS = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic start,
    output logic busy,
    output logic step,
    output logic load
);
    localparam int unsigned CW = $clog2(STEPS + 1);
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    logic [CW-1:0] cnt;

    // Remainder and quotient are reloaded on either divisor byte write.
    assign load = arm | start;
    assign step = busy;

    // Counter and busy flag: start clears the count, the last step ends the run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (arm) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == LAST) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    assert_arm_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !start) |=> !busy);

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= LAST));

    assert_run_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(arm)) |-> ($past(cnt) == LAST));
endmodule

// File: rtl/fd_shift_datapath.sv
// Module: restoring divide datapath. A remainder shift register one bit wider
// than the operands, an adder with the inverted divisor, and a quotient shift
// register fed by the carry-out. A successful subtract writes back the
// difference already shifted left. Assumes dividend < 2 * divisor.
module fd_shift_datapath #(
    parameter int unsigned W     = 16,
    parameter int unsigned STEPS = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [W-1:0]     dvd,
    input  logic [W-1:0]     dvs_inv,
    output logic [STEPS-1:0] quo
);
    localparam int unsigned RW = W + 1;

    logic [RW-1:0] rem;
    logic [RW:0]   sum;
    logic          carry;
    logic [RW-1:0] diff_shl;
    logic [RW-1:0] rem_shl;

    // Trial subtract: rem + ~divisor + 1, with the divisor widened to RW bits.
    always_comb begin
        sum      = {1'b0, rem} + {1'b0, 1'b1, dvs_inv} + {{RW{1'b0}}, 1'b1};
        carry    = sum[RW];
        diff_shl = sum[RW-1:0] << 1;
        rem_shl  = rem << 1;
    end

    // Remainder and quotient registers: reload on arm/start, else one step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem <= '0;
            quo <= '0;
        end else if (load) begin
            rem <= {1'b0, dvd};
            quo <= '0;
        end else if (step) begin
            quo <= {quo[STEPS-2:0], carry};
            rem <= carry ? diff_shl : rem_shl;
        end
    end

    assert_load_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (quo == '0));

    assert_quo_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(quo));

    assert_quo_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (quo[STEPS-1:1] == $past(quo[STEPS-2:0])));
endmodule

// File: rtl/frac_div.sv
// Module: top of the fractional divider. Ties the operand latches, the step
// sequencer and the datapath to the byte-wide host strobes. The quotient is
// presented left-aligned at the operand width.
module frac_div
    import frac_div_pkg::*;
#(
    parameter int unsigned W = DIV_W_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_dvd_hi,
    input  logic           wr_dvd_lo,
    input  logic           wr_dvs_hi,
    input  logic           wr_dvs_lo,
    input  logic [W/2-1:0] wr_data,
    output logic [W-1:0]   rd_quot,
    output logic           busy
);
    localparam int unsigned STEPS = W - 1;

    wr_strb_t         strb;
    logic [W-1:0]     dvd_q;
    logic [W-1:0]     dvs_inv_q;
    logic             step;
    logic             load;
    logic [STEPS-1:0] quo;

    assign strb = '{dvd_hi: wr_dvd_hi, dvd_lo: wr_dvd_lo,
                    dvs_hi: wr_dvs_hi, dvs_lo: wr_dvs_lo};

    fd_operand_latch #(.W(W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .strb      (strb),
        .wr_data   (wr_data),
        .dvd_q     (dvd_q),
        .dvs_inv_q (dvs_inv_q)
    );

    fd_step_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (wr_dvs_hi),
        .start (wr_dvs_lo),
        .busy  (busy),
        .step  (step),
        .load  (load)
    );

    fd_shift_datapath #(.W(W), .STEPS(STEPS)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .dvd     (dvd_q),
        .dvs_inv (dvs_inv_q),
        .quo     (quo)
    );

    assign rd_quot = {quo, {(W - STEPS){1'b0}}};
endmodule

// File: tb/frac_div_tb.sv
module frac_div_tb;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_dvd_hi = 1'b0;
    logic        wr_dvd_lo = 1'b0;
    logic        wr_dvs_hi = 1'b0;
    logic        wr_dvs_lo = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [15:0] rd_quot;
    logic        busy;

    int compared = 0;
    int mismatched = 0;

    always #(PERIOD/2) clk = ~clk;

    frac_div u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_dvd_hi(wr_dvd_hi), .wr_dvd_lo(wr_dvd_lo),
        .wr_dvs_hi(wr_dvs_hi), .wr_dvs_lo(wr_dvs_lo),
        .wr_data(wr_data), .rd_quot(rd_quot), .busy(busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Strobe kind: 0 dvd_hi, 1 dvd_lo, 2 dvs_hi, 3 dvs_lo. Returns at the
    // falling edge after the write has been clocked in.
    task automatic wr(input int kind, input logic [7:0] d);
        @(negedge clk);
        wr_data   = d;
        wr_dvd_hi = (kind == 0);
        wr_dvd_lo = (kind == 1);
        wr_dvs_hi = (kind == 2);
        wr_dvs_lo = (kind == 3);
        @(negedge clk);
        wr_dvd_hi = 1'b0; wr_dvd_lo = 1'b0;
        wr_dvs_hi = 1'b0; wr_dvs_lo = 1'b0;
    endtask

    function automatic logic [15:0] expect_q(input int d, input int v);
        int q;
        q = (d * 16384) / v;
        return {q[14:0], 1'b0};
    endfunction

    // Count busy cycles from the sample right after a start.
    task automatic wait_done(output int n);
        n = 0;
        while (busy && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_div(input int d, input int v, input bit set_dvd, input string tag);
        int n;
        if (set_dvd) begin
            wr(0, d[15:8]);
            wr(1, d[7:0]);
        end
        wr(2, v[15:8]);
        wr(3, v[7:0]);
        check("R4 busy after start", 32'(busy), 32'd1);
        wait_done(n);
        check("R5 busy length", n, 15);
        check(tag, 32'(rd_quot), 32'(expect_q(d, v)));
    endtask

    initial begin
        #(PERIOD * 150000);
        compared++;
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int n;
        logic [15:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 quot", 32'(rd_quot), 32'd0);

        // R7: required examples
        do_div(16'h4000, 16'h4000, 1, "R7 4000/4000");
        do_div(16'h5555, 16'h4000, 1, "R7 5555/4000");
        do_div(16'h2AAA, 16'h4000, 1, "R7 2AAA/4000");
        do_div(16'h2AAA, 16'h2AAA, 1, "R7 2AAA/2AAA");
        do_div(16'h5555, 16'h5555, 1, "R7 5555/5555");

        // R2: dividend reused with divisor-only writes
        do_div(16'h6000, 16'h4000, 1, "R2 first use");
        do_div(16'h6000, 16'h7000, 0, "R2 reuse");
        do_div(16'h6000, 16'h3001, 0, "R2 reuse again");

        // R9: dividend writes after a result leave it unchanged
        held = rd_quot;
        wr(0, 8'h12);
        wr(1, 8'h34);
        repeat (2) @(negedge clk);
        check("R9 quot held", 32'(rd_quot), 32'(held));
        check("R9 busy idle", 32'(busy), 32'd0);

        // R3: divisor upper write clears the quotient
        wr(2, 8'h40);
        check("R3 quot cleared", 32'(rd_quot), 32'd0);
        check("R3 not busy", 32'(busy), 32'd0);

        // R3: upper write during a run aborts it
        wr(0, 8'h30); wr(1, 8'h00);
        wr(2, 8'h40); wr(3, 8'h00);
        repeat (3) @(negedge clk);
        wr(2, 8'h40);
        check("R3 abort busy", 32'(busy), 32'd0);
        check("R3 abort quot", 32'(rd_quot), 32'd0);

        // R8 and R9: restart mid-run with new dividend and divisor low byte
        wr(0, 8'h30); wr(1, 8'h00);
        wr(2, 8'h40); wr(3, 8'h00);
        repeat (3) @(negedge clk);
        wr(0, 8'h50); wr(1, 8'h00);
        check("R9 run continues", 32'(busy), 32'd1);
        wr(3, 8'h80);
        wait_done(n);
        check("R8 restart length", n, 15);
        check("R8 restart result", 32'(rd_quot), 32'(expect_q(16'h5000, 16'h4080)));

        // R6: sweep divisors over the range, dividends up to 2*divisor-1
        for (int i = 0; i < 64; i++) begin
            int v;
            int lim;
            v = (i == 0) ? 1 : ((i == 63) ? 16'hFFFF : i * 1039 + 7);
            lim = 2 * v - 1;
            if (lim > 16'hFFFF) lim = 16'hFFFF;
            for (int j = 0; j < 40; j++) begin
                do_div((lim * j) / 39, v, 1, "R6 sweep");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule